// File: doc/BRIEF.md
# Address-Space-Tagged Translation Cache with Flush Command Decoder

This block caches page translations for a 32-bit I/O virtual address space with 4 KiB pages. Each line holds a 7-bit address-space identifier, a 20-bit virtual page number, a 20-bit physical frame number and three permission bits (read, write, non-secure). A client presents an identifier and a page number on a valid/ready lookup stream. One cycle later it receives a hit or miss with the frame and permissions on a response stream. A page walker that resolves a miss installs the result through a refill stream.

Entries are removed by writing a 32-bit command word. The word selects an address match mode (every address, one 4 MiB section or one 16 KiB group) and can also restrict the flush to a single identifier. A configuration word sets how many lines take part in lookup and replacement. The same word carries two policy bits that are passed on to the neighbouring walker and arbiter. Replacement is round-robin over the active lines.

Back-pressure rules: `lk_ready` is high whenever no response is pending or the pending one is being taken (`rsp_ready` high). A response stays valid and unchanged until it is taken. `rf_ready` is low only during a configuration write. A refill offered in that cycle is not taken.

Top module: `iotlb_asid`

## Requirements
- R1: After reset no response is pending, `lk_ready` is 1, both policy outputs are 0, every line is invalid and all lines are active.
- R2: A lookup accepted on a clock edge gives `rsp_valid`=1 after that edge. `rsp_hit` is 1 exactly when an active valid line holds both the same identifier and the same page number. On a hit the line's frame and permissions are returned; on a miss both are zero.
- R3: While `rsp_valid` is 1 and `rsp_ready` is 0, `lk_ready` is 0 and the response fields hold their values.
- R4: A refill whose identifier and page number are already held by an active line overwrites that line and does not move the replacement pointer.
- R5: A configuration write copies bit 29 to `cfg_hit_under_miss` and bit 28 to `cfg_rr_arb`. The active count is the low bits ANDed with 2*LINES-1, clamped to LINES. Lines at or above the count are invalidated and never hit. With a count of 0, refills are dropped. `rf_ready` is 0 in the cycle of the configuration write.
- R6: Flush command bits [1:0] select the address match mode. Mode 0 matches every address. Mode 1 matches nothing, so the flush leaves every line in place.
- R7: Mode 2 (section) removes the lines whose page-number bits [19:10] equal command bits [19:10].
- R8: Mode 3 (group) removes the lines whose page-number bits [19:2] equal command bits [19:2]. This covers four consecutive 4 KiB pages.
- R9: When command bit 31 is 1, only lines whose identifier equals command bits [30:24] are removed. When bit 31 is 0, matching lines of every identifier are removed.
- R10: A flush takes effect on the edge that ends the write cycle. A lookup accepted in that same cycle sees the contents from before the flush.
- R11: A refill accepted in the same cycle as a flush is applied after the flush, so the new entry survives even if the flush matches it.
- R12: A refill that misses writes the line at the round-robin pointer, then moves the pointer to the next line. The pointer wraps to 0 after the last active line. Once the active lines are full, the next refill evicts the oldest one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word |
| cfg_hit_under_miss | output | 1 | Policy bit for the walker (config bit 29) |
| cfg_rr_arb | output | 1 | Policy bit for the arbiter (config bit 28) |
| flush_we | input | 1 | Flush command write strobe |
| flush_cmd | input | 32 | Flush command word |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request ready |
| lk_asid | input | 7 | Lookup address-space identifier |
| lk_vpn | input | 20 | Lookup virtual page number |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response ready |
| rsp_hit | output | 1 | Lookup hit |
| rsp_pfn | output | 20 | Physical frame number on a hit |
| rsp_perm | output | 3 | Permissions on a hit |
| rf_valid | input | 1 | Refill valid |
| rf_ready | output | 1 | Refill ready |
| rf_asid | input | 7 | Refill identifier |
| rf_vpn | input | 20 | Refill virtual page number |
| rf_pfn | input | 20 | Refill frame number |
| rf_perm | input | 3 | Refill permissions |

## Verification
A line that is wrongly left valid, cleared, or written in the wrong place shows up only on the response stream. It appears as a wrong hit, miss or frame on the first lookup of that key after the edge that corrupted it. A replacement pointer that is off by one stays hidden until the active lines have wrapped: the wrong victim only appears one refill after they are full. A flush decode error shows one cycle after the command write, as a survivor or as a lost neighbour in the adjacent section or group.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int ASID_W = 7;
  localparam int VPN_W  = 20;
  localparam int PFN_W  = 20;
  localparam int PERM_W = 3;
  // page-number bit where a 4 MiB section and a 16 KiB group start
  localparam int SEC_LO = 10;
  localparam int GRP_LO = 2;
  // command and configuration field positions
  localparam int CMD_ASID_EN = 31;
  localparam int CMD_ASID_LO = 24;
  localparam int CFG_HUM_BIT = 29;
  localparam int CFG_RR_BIT  = 28;

  typedef enum logic [1:0] {
    FM_ALL     = 2'd0,
    FM_NONE    = 2'd1,
    FM_SECTION = 2'd2,
    FM_GROUP   = 2'd3
  } fmode_e;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PFN_W-1:0]  pfn;
    logic [PERM_W-1:0] perm;
  } tlb_ent_t;
endpackage

// File: rtl/iotlb_cfg.sv
module iotlb_cfg
  import iotlb_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [31:0]      cfg_wdata,
  output logic [$clog2(LINES):0] active_cnt,
  output logic [LINES-1:0] active_mask,
  output logic [LINES-1:0] trim,
  output logic             hum,
  output logic             rr
);
  localparam int CNT_W = $clog2(LINES) + 1;
  localparam logic [CNT_W-1:0] CNT_MASK = CNT_W'(2 * LINES - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(LINES);

  logic [CNT_W-1:0] field, new_cnt;

  assign field   = cfg_wdata[CNT_W-1:0] & CNT_MASK;
  assign new_cnt = (field > CNT_MAX) ? CNT_MAX : field;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_cnt <= CNT_MAX;
      hum        <= 1'b0;
      rr         <= 1'b0;
    end else if (cfg_we) begin
      active_cnt <= new_cnt;
      hum        <= cfg_wdata[CFG_HUM_BIT];
      rr         <= cfg_wdata[CFG_RR_BIT];
    end
  end

  for (genvar i = 0; i < LINES; i++) begin : g_mask
    assign active_mask[i] = CNT_W'(i) < active_cnt;
    assign trim[i]        = cfg_we && !(CNT_W'(i) < new_cnt);
  end
endmodule

// File: rtl/iotlb_repl.sv
module iotlb_repl #(
  parameter int LINES = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(LINES):0]        active_cnt,
  input  logic                          adv,
  output logic [$clog2(LINES)-1:0]      victim,
  output logic                          victim_ok
);
  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = IDX_W + 1;

  logic [IDX_W-1:0] ptr;
  logic [CNT_W-1:0] nxt;

  // a pointer left beyond a shrunk active range restarts at line 0
  assign victim    = ({1'b0, ptr} < active_cnt) ? ptr : '0;
  assign victim_ok = active_cnt != '0;
  assign nxt       = {1'b0, victim} + CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= (nxt >= active_cnt) ? '0 : nxt[IDX_W-1:0];
  end
endmodule

// File: rtl/iotlb_flush_dec.sv
module iotlb_flush_dec
  import iotlb_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                  flush_we,
  input  logic [31:0]           flush_cmd,
  input  logic [LINES-1:0]      valid,
  input  tlb_ent_t [LINES-1:0]  ents,
  output logic [LINES-1:0]      kill
);
  fmode_e            mode;
  logic              asid_en;
  logic [ASID_W-1:0] asid_sel;

  assign mode     = fmode_e'(flush_cmd[1:0]);
  assign asid_en  = flush_cmd[CMD_ASID_EN];
  assign asid_sel = flush_cmd[CMD_ASID_LO +: ASID_W];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic addr_ok, asid_ok;
    always_comb begin
      unique case (mode)
        FM_ALL:     addr_ok = 1'b1;
        FM_SECTION: addr_ok = ents[i].vpn[VPN_W-1:SEC_LO] == flush_cmd[VPN_W-1:SEC_LO];
        FM_GROUP:   addr_ok = ents[i].vpn[VPN_W-1:GRP_LO] == flush_cmd[VPN_W-1:GRP_LO];
        default:    addr_ok = 1'b0;
      endcase
      asid_ok = !asid_en || (ents[i].asid == asid_sel);
    end
    assign kill[i] = flush_we && valid[i] && addr_ok && asid_ok;
  end
endmodule

// File: rtl/iotlb_store.sv
module iotlb_store
  import iotlb_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [LINES-1:0]           kill,
  input  logic                       wr_en,
  input  logic [$clog2(LINES)-1:0]   wr_idx,
  input  tlb_ent_t                   wr_ent,
  input  logic [LINES-1:0]           active_mask,
  input  logic [ASID_W-1:0]          lk_asid,
  input  logic [VPN_W-1:0]           lk_vpn,
  input  logic [ASID_W-1:0]          rf_asid,
  input  logic [VPN_W-1:0]           rf_vpn,
  output logic [LINES-1:0]           valid,
  output tlb_ent_t [LINES-1:0]       ents,
  output logic [LINES-1:0]           lk_hit_vec,
  output logic [LINES-1:0]           rf_hit_vec
);
  localparam int IDX_W = $clog2(LINES);

  logic [LINES-1:0] wr_vec;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    assign wr_vec[i] = wr_en && (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (wr_vec[i]) ents[i] <= wr_ent;
    end

    assign lk_hit_vec[i] = valid[i] && active_mask[i] &&
                           ents[i].asid == lk_asid && ents[i].vpn == lk_vpn;
    assign rf_hit_vec[i] = valid[i] && active_mask[i] &&
                           ents[i].asid == rf_asid && ents[i].vpn == rf_vpn;
  end

  // removal first, then the write, so a same-cycle refill survives
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid <= '0;
    else        valid <= (valid & ~kill) | wr_vec;
  end
endmodule

// File: rtl/iotlb_asid.sv
module iotlb_asid
  import iotlb_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [31:0]       cfg_wdata,
  output logic              cfg_hit_under_miss,
  output logic              cfg_rr_arb,
  input  logic              flush_we,
  input  logic [31:0]       flush_cmd,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic [PFN_W-1:0]  rsp_pfn,
  output logic [PERM_W-1:0] rsp_perm,
  input  logic              rf_valid,
  output logic              rf_ready,
  input  logic [ASID_W-1:0] rf_asid,
  input  logic [VPN_W-1:0]  rf_vpn,
  input  logic [PFN_W-1:0]  rf_pfn,
  input  logic [PERM_W-1:0] rf_perm
);
  localparam int IDX_W = $clog2(LINES);
  localparam int CNT_W = IDX_W + 1;

  logic [CNT_W-1:0]     active_cnt;
  logic [LINES-1:0]     active_mask, trim, flush_kill, valid_vec;
  logic [LINES-1:0]     lk_hit_vec, rf_hit_vec;
  tlb_ent_t [LINES-1:0] ents;
  logic [IDX_W-1:0]     victim, dup_idx, wr_idx;
  logic                 victim_ok, rf_fire, rf_dup, wr_en, adv, lk_fire;
  logic [PFN_W-1:0]     sel_pfn;
  logic [PERM_W-1:0]    sel_perm;
  tlb_ent_t             wr_ent;

  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign rf_ready = !cfg_we;
  assign rf_fire  = rf_valid && rf_ready;

  iotlb_cfg #(.LINES(LINES)) u_cfg (
    .clk, .rst_n, .cfg_we, .cfg_wdata,
    .active_cnt, .active_mask, .trim,
    .hum(cfg_hit_under_miss), .rr(cfg_rr_arb)
  );

  iotlb_flush_dec #(.LINES(LINES)) u_flush (
    .flush_we, .flush_cmd, .valid(valid_vec), .ents, .kill(flush_kill)
  );

  iotlb_repl #(.LINES(LINES)) u_repl (
    .clk, .rst_n, .active_cnt, .adv, .victim, .victim_ok
  );

  // refill targets the line already holding the key, else the victim
  always_comb begin
    dup_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (rf_hit_vec[i]) dup_idx = dup_idx | IDX_W'(i);
  end

  assign rf_dup = |rf_hit_vec;
  assign wr_en  = rf_fire && (rf_dup || victim_ok);
  assign adv    = rf_fire && !rf_dup && victim_ok;
  assign wr_idx = rf_dup ? dup_idx : victim;
  assign wr_ent = '{asid: rf_asid, vpn: rf_vpn, pfn: rf_pfn, perm: rf_perm};

  iotlb_store #(.LINES(LINES)) u_store (
    .clk, .rst_n,
    .kill(flush_kill | trim),
    .wr_en, .wr_idx, .wr_ent, .active_mask,
    .lk_asid, .lk_vpn, .rf_asid, .rf_vpn,
    .valid(valid_vec), .ents, .lk_hit_vec, .rf_hit_vec
  );

  always_comb begin
    sel_pfn  = '0;
    sel_perm = '0;
    for (int i = 0; i < LINES; i++) begin
      if (lk_hit_vec[i]) begin
        sel_pfn  = sel_pfn | ents[i].pfn;
        sel_perm = sel_perm | ents[i].perm;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_pfn   <= '0;
      rsp_perm  <= '0;
    end else if (lk_fire) begin
      rsp_valid <= 1'b1;
      rsp_hit   <= |lk_hit_vec;
      rsp_pfn   <= sel_pfn;
      rsp_perm  <= sel_perm;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/iotlb_asid_chk.sv
module iotlb_asid_chk #(
  parameter int LINES = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic             rsp_hit,
  input logic [19:0]      rsp_pfn,
  input logic [2:0]       rsp_perm,
  input logic             cfg_we,
  input logic             flush_we,
  input logic [31:0]      flush_cmd,
  input logic             rf_valid,
  input logic [LINES-1:0] lk_hit_vec,
  input logic [LINES-1:0] valid_vec,
  input logic [LINES-1:0] active_mask
);
  // R3: a stalled response keeps its contents
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_hit) &&
      $stable(rsp_pfn) && $stable(rsp_perm));

  // R4: overwrite-on-match keeps keys unique, so at most one line hits
  p_single_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec));

  // R5: no valid line sits outside the active range
  p_trim_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_vec & ~active_mask) == '0);

  // R6: a global flush of every address leaves nothing behind
  p_flush_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_we && flush_cmd[1:0] == 2'd0 && !flush_cmd[31] && !rf_valid
      |=> valid_vec == '0);

  // R6: mode 1 removes no line
  p_flush_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush_we && flush_cmd[1:0] == 2'd1 && !cfg_we
      |=> ($past(valid_vec) & ~valid_vec) == '0);

  // R11: a refill taken alongside a flush leaves a valid line
  p_refill_survives_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rf_valid && !cfg_we && flush_we && active_mask != '0 |=> valid_vec != '0);
endmodule

bind iotlb_asid iotlb_asid_chk #(.LINES(LINES)) u_chk (
  .clk, .rst_n, .rsp_valid, .rsp_ready, .rsp_hit, .rsp_pfn, .rsp_perm,
  .cfg_we, .flush_we, .flush_cmd, .rf_valid,
  .lk_hit_vec, .valid_vec, .active_mask
);

// File: tb/iotlb_asid_bench.sv
module iotlb_asid_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, flush_we = 0, lk_valid = 0, rsp_ready = 1, rf_valid = 0;
  logic [31:0] cfg_wdata = 0, flush_cmd = 0;
  logic [6:0]  lk_asid = 0, rf_asid = 0;
  logic [19:0] lk_vpn = 0, rf_vpn = 0, rf_pfn = 0;
  logic [2:0]  rf_perm = 0;
  logic        cfg_hit_under_miss, cfg_rr_arb, lk_ready, rsp_valid, rsp_hit, rf_ready;
  logic [19:0] rsp_pfn;
  logic [2:0]  rsp_perm;

  always #(CLK_PERIOD/2) clk = ~clk;

  iotlb_asid #(.LINES(LINES)) u_iotlb_asid (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // reference state
  bit        mv[LINES];
  bit [6:0]  ma[LINES];
  bit [19:0] mvp[LINES], mpf[LINES];
  bit [2:0]  mpe[LINES];
  int        mptr = 0, mcnt = LINES;
  bit        mhum = 0, mrr = 0;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit flush_hits(int i, bit [31:0] fc);
    bit a_ok, s_ok;
    case (fc[1:0])
      2'd0: a_ok = 1;
      2'd2: a_ok = mvp[i][19:10] == fc[19:10];
      2'd3: a_ok = mvp[i][19:2] == fc[19:2];
      default: a_ok = 0;
    endcase
    s_ok = !fc[31] || (ma[i] == fc[30:24]);
    return mv[i] && a_ok && s_ok;
  endfunction

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic step(bit lk, bit [6:0] la, bit [19:0] lv,
                      bit rf, bit [6:0] ra, bit [19:0] rv, bit [19:0] rp, bit [2:0] rpe,
                      bit fl, bit [31:0] fc, bit cf, bit [31:0] cw,
                      string tag, int exp_hit);
    bit e_hit = 0; bit [19:0] e_pfn = 0; bit [2:0] e_perm = 0;
    int tgt = -1; bit adv = 0;
    lk_valid = lk; lk_asid = la; lk_vpn = lv;
    rf_valid = rf; rf_asid = ra; rf_vpn = rv; rf_pfn = rp; rf_perm = rpe;
    flush_we = fl; flush_cmd = fc; cfg_we = cf; cfg_wdata = cw;
    #1;
    if (rf || cf) chk(rf_ready == !cf, "R5 rf_ready", rf_ready, !cf);
    for (int i = 0; i < mcnt; i++)
      if (mv[i] && ma[i] == la && mvp[i] == lv) begin
        e_hit = 1; e_pfn = mpf[i]; e_perm = mpe[i];
      end
    if (rf && !cf && mcnt != 0) begin
      for (int i = 0; i < mcnt; i++)
        if (mv[i] && ma[i] == ra && mvp[i] == rv) tgt = i;
      if (tgt < 0) begin tgt = (mptr < mcnt) ? mptr : 0; adv = 1; end
    end
    @(posedge clk);
    if (fl) for (int i = 0; i < LINES; i++) if (flush_hits(i, fc)) mv[i] = 0;
    if (tgt >= 0) begin
      mv[tgt] = 1; ma[tgt] = ra; mvp[tgt] = rv; mpf[tgt] = rp; mpe[tgt] = rpe;
      if (adv) mptr = (tgt + 1 >= mcnt) ? 0 : tgt + 1;
    end
    if (cf) begin
      int f = int'(cw[4:0]) & (2*LINES - 1);
      mcnt = (f > LINES) ? LINES : f;
      for (int i = mcnt; i < LINES; i++) mv[i] = 0;
      mhum = cw[29]; mrr = cw[28];
    end
    @(negedge clk);
    lk_valid = 0; rf_valid = 0; flush_we = 0; cfg_we = 0;
    if (lk) begin
      chk(rsp_valid == 1, {tag, " rsp_valid"}, rsp_valid, 1);
      chk(rsp_hit == e_hit, {tag, " hit"}, rsp_hit, e_hit);
      chk(rsp_pfn == e_pfn && rsp_perm == e_perm, {tag, " data"},
          {rsp_perm, rsp_pfn}, {e_perm, e_pfn});
      if (exp_hit >= 0) chk(rsp_hit == exp_hit[0], {tag, " directed"}, rsp_hit, exp_hit);
    end
    if (cf) chk(cfg_hit_under_miss == mhum && cfg_rr_arb == mrr, "R5 policy bits",
                {cfg_hit_under_miss, cfg_rr_arb}, {mhum, mrr});
  endtask

  task automatic look(bit [6:0] a, bit [19:0] v, string tag, int e);
    step(1, a, v, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag, e);
  endtask
  task automatic fill(bit [6:0] a, bit [19:0] v, bit [19:0] p);
    step(0, 0, 0, 1, a, v, p, 3'(p), 0, 0, 0, 0, "fill", -1);
  endtask
  task automatic flush(bit [31:0] c);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1, c, 0, 0, "flush", -1);
  endtask
  task automatic cfg(bit [31:0] w);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, w, "cfg", -1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < LINES; i++) mv[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    chk(lk_ready == 1, "R1 lk_ready", lk_ready, 1);
    chk(cfg_hit_under_miss == 0 && cfg_rr_arb == 0, "R1 policy", {cfg_hit_under_miss, cfg_rr_arb}, 0);
    look(7'd5, 20'h12345, "R1 empty", 0);

    // R2 basic hit and identifier separation
    fill(7'd5, 20'h12345, 20'hABCDE);
    look(7'd5, 20'h12345, "R2 hit", 1);
    look(7'd6, 20'h12345, "R2 other asid", 0);
    look(7'd5, 20'h12346, "R2 other vpn", 0);

    // R12 round-robin eviction after filling all lines
    flush(32'h0);
    for (int i = 0; i < LINES; i++) fill(7'd1, 20'h00100 + 20'(i), 20'h00500 + 20'(i));
    look(7'd1, 20'h00100, "R12 full oldest present", 1);
    fill(7'd1, 20'h00200, 20'h00777);
    look(7'd1, 20'h00100, "R12 oldest evicted", 0);
    look(7'd1, 20'h00101, "R12 next kept", 1);
    // R4 overwrite in place, pointer unchanged
    fill(7'd1, 20'h00103, 20'h00999);
    look(7'd1, 20'h00103, "R4 overwrite", 1);
    look(7'd1, 20'h00101, "R4 no eviction", 1);

    // R7 section flush
    flush(32'h0);
    fill(7'd1, 20'h00C05, 20'h1); fill(7'd1, 20'h00C3F, 20'h2); fill(7'd1, 20'h01005, 20'h3);
    flush((32'd3 << 10) | 32'd2);
    look(7'd1, 20'h00C05, "R7 in section", 0);
    look(7'd1, 20'h00C3F, "R7 in section top", 0);
    look(7'd1, 20'h01005, "R7 next section", 1);

    // R8 group flush
    fill(7'd1, 20'h02004, 20'h4); fill(7'd1, 20'h02007, 20'h5); fill(7'd1, 20'h02008, 20'h6);
    flush(32'h00002007);
    look(7'd1, 20'h02004, "R8 group low", 0);
    look(7'd1, 20'h02007, "R8 group high", 0);
    look(7'd1, 20'h02008, "R8 next group", 1);

    // R9 identifier-restricted flush, then unrestricted
    fill(7'd1, 20'h03000, 20'h7); fill(7'd2, 20'h03000, 20'h8);
    flush((32'd1 << 31) | (32'd1 << 24));
    look(7'd1, 20'h03000, "R9 selected asid", 0);
    look(7'd2, 20'h03000, "R9 other asid", 1);
    flush(32'h0);
    look(7'd2, 20'h03000, "R9 all asids", 0);

    // R6 mode 1 removes nothing
    fill(7'd3, 20'h04000, 20'h9);
    flush(32'h1);
    look(7'd3, 20'h04000, "R6 mode1", 1);

    // R10 lookup in the flush cycle sees old contents
    step(1, 7'd3, 20'h04000, 0, 0, 0, 0, 0, 1, 32'h0, 0, 0, "R10 same cycle", 1);
    look(7'd3, 20'h04000, "R10 after", 0);

    // R11 refill alongside a flush survives
    step(0, 0, 0, 1, 7'd4, 20'h05000, 20'hA, 3'd5, 1, 32'h0, 0, 0, "R11", -1);
    look(7'd4, 20'h05000, "R11 survives", 1);

    // R3 back-pressure
    rsp_ready = 0; lk_valid = 1; lk_asid = 7'd4; lk_vpn = 20'h05000;
    @(negedge clk);
    lk_asid = 7'd4; lk_vpn = 20'h0FFFF; #1;
    chk(lk_ready == 0, "R3 lk_ready low", lk_ready, 0);
    @(negedge clk);
    chk(rsp_valid == 1 && rsp_hit == 1 && rsp_pfn == 20'hA, "R3 held", {rsp_valid, rsp_hit, rsp_pfn}, {2'b11, 20'hA});
    rsp_ready = 1;
    @(negedge clk);
    lk_valid = 0;
    chk(rsp_valid == 1 && rsp_hit == 0, "R3 next taken", {rsp_valid, rsp_hit}, 2'b10);
    @(negedge clk);
    chk(rsp_valid == 0, "R3 drained", rsp_valid, 0);

    // R5 config: count 0x12 masks to 2, policy bits set
    cfg((32'd1 << 29) | (32'd1 << 28) | 32'h12);
    look(7'd4, 20'h05000, "R5 trimmed or kept", -1);
    fill(7'd1, 20'h06000, 20'h1); fill(7'd1, 20'h06001, 20'h2); fill(7'd1, 20'h06002, 20'h3);
    look(7'd1, 20'h06000, "R5 two lines evict", -1);
    look(7'd1, 20'h06002, "R5 newest", 1);
    step(0, 0, 0, 1, 7'd1, 20'h06003, 20'h4, 0, 0, 0, 1, 32'h0, "R5 refill in cfg", -1);
    fill(7'd1, 20'h06004, 20'h5);
    look(7'd1, 20'h06004, "R5 count zero drops", 0);
    cfg(32'h1F);
    look(7'd1, 20'h06003, "R5 dropped refill", 0);

    // random phase against the reference
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      bit lk = ($urandom % 10) < 7;
      bit rf = ($urandom % 10) < 3;
      bit fl = ($urandom % 20) == 0;
      bit cf = ($urandom % 100) == 0;
      bit [19:0] v1 = (($urandom % 2) ? 20'h00400 : 20'h00C00) + 20'($urandom % 12);
      bit [19:0] v2 = (($urandom % 2) ? 20'h00400 : 20'h00C00) + 20'($urandom % 12);
      bit [19:0] v3 = (($urandom % 2) ? 20'h00400 : 20'h00C00) + 20'($urandom % 12);
      bit [31:0] fc = {1'($urandom), 7'($urandom % 4), 4'b0, v3[19:2], 2'($urandom)};
      bit [31:0] cw = {2'b0, 2'($urandom), 23'b0, 5'(1 + $urandom % 15)};
      step(lk, 7'($urandom % 4), v1, rf, 7'($urandom % 4), v2, 20'($urandom), 3'($urandom),
           fl, fc, cf, cw, "R2 random", -1);
    end
    finish_run();
  end
endmodule